// File: doc/BRIEF.md
# CAN Operating-Mode Gate

The block sits between a CAN bit-level protocol engine and the TX/RX pins and applies one operating mode at a time: configuration, normal, listen-only, loopback or error-recognition. The mode decides four things. It decides whether the engine's transmit bit reaches the pin, and whether the pin driver is enabled. It decides whether the engine hears the bus or its own transmit stream. It decides whether the error counters are cleared or frozen. It also decides whether frames with errors are kept by the receive-buffer logic.

A mode request is sampled on every clock. It is adopted only while the engine reports the bus idle, so a mode never changes in the middle of a frame. The mode in effect is reported back on an acknowledge output. The pin and receive paths are combinational, so they add no latency to the bit stream. The only registered strobe is the request to copy a partly assembled frame after an error.

Top module: `can_mode_gate`

## Requirements
- R1: While reset is asserted, the gate behaves as follows: mode_ack_o reads 0 (configuration), pin_tx_oe_o=0, pin_tx_o=1, eng_rx_o=1 and rx_en_o=0.
- R2: mode_req_i uses these codes: 0 configuration, 1 normal, 2 listen-only, 3 loopback, 4 error-recognition. A valid code is adopted at a clock edge only when bus_idle_i=1. With bus_idle_i=0 the mode is unchanged. The new mode is visible on mode_ack_o after that edge.
- R3: In normal mode, pin_tx_o follows eng_tx_i, pin_tx_oe_o=1, and eng_rx_o follows pin_rx_i. ack_ignore_o, cnt_hold_o, cnt_clr_o and keep_err_o are all 0.
- R4: In listen-only mode, pin_tx_o=1 and pin_tx_oe_o=0 whatever the engine sends, and eng_rx_o follows pin_rx_i. cnt_clr_o=1, cnt_hold_o=1 and keep_err_o=1.
- R5: In loopback mode, pin_tx_o=1 and pin_tx_oe_o=0. eng_rx_o follows eng_tx_i whatever pin_rx_i is, and ack_ignore_o=1.
- R6: In error-recognition mode, pin_tx_oe_o=1. pin_tx_o is 1 while eng_err_flag_i=1 and otherwise follows eng_tx_i. cnt_hold_o=1, keep_err_o=1, cnt_clr_o=0.
- R7: copy_part_o is 1 for the one cycle after an edge at which err_evt_i=1 and the mode in effect was listen-only or error-recognition. In any other mode it stays 0.
- R8: Request codes 5, 6 and 7 are ignored: the mode is unchanged even when bus_idle_i=1.
- R9: In configuration mode, rx_en_o=0, eng_rx_o=1, pin_tx_o=1 and pin_tx_oe_o=0. In every other mode rx_en_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_req_i | input | 3 | Requested mode code |
| bus_idle_i | input | 1 | Engine reports bus idle; mode may change |
| eng_tx_i | input | 1 | Transmit bit from protocol engine |
| eng_err_flag_i | input | 1 | Engine is currently sending an error flag |
| pin_rx_i | input | 1 | Bit from RX pin |
| err_evt_i | input | 1 | Error detected in current frame |
| pin_tx_o | output | 1 | Bit to TX pin, 1 is recessive |
| pin_tx_oe_o | output | 1 | TX pin drive enable |
| eng_rx_o | output | 1 | Receive bit presented to the engine |
| ack_ignore_o | output | 1 | Engine must not fault a missing ACK |
| cnt_hold_o | output | 1 | Freeze error counters |
| cnt_clr_o | output | 1 | Clear error counters |
| keep_err_o | output | 1 | Receive buffers keep frames with errors |
| copy_part_o | output | 1 | Copy the partial frame into the receive buffer |
| rx_en_o | output | 1 | Reception enabled |
| mode_ack_o | output | 3 | Mode currently in effect |

## Verification
A corrupted mode register shows up at once on mode_ack_o. Within the same cycle it also shows up as a wrong pin drive or receive source, for example a TX pin driven in a silent mode or the bus echoed in loopback. A request taken while the bus is busy, or an invalid code that is accepted, shows one edge later. A wrong error-policy decision appears on the counter and keep strobes immediately, and on copy_part_o one cycle after the error event.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_CFG    = 3'd0,
    MD_NORMAL = 3'd1,
    MD_LISTEN = 3'd2,
    MD_LOOP   = 3'd3,
    MD_ERRREC = 3'd4
  } mode_e;

  localparam logic [MODE_W-1:0] MODE_MAX = 3'd4;

  function automatic logic req_valid(input logic [MODE_W-1:0] code);
    return code <= MODE_MAX;
  endfunction

  function automatic logic is_silent(input mode_e m);
    return (m == MD_CFG) || (m == MD_LISTEN) || (m == MD_LOOP);
  endfunction
endpackage

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] req_i,
  input  logic              bus_idle_i,
  output mode_e             mode_o
);
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               mode_q <= MD_CFG;
    else if (bus_idle_i && req_valid(req_i))   mode_q <= mode_e'(req_i);
  end

  assign mode_o = mode_q;

  // R2
  idle_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(bus_idle_i));

  // R8
  legal_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q <= MODE_MAX);
endmodule

// File: rtl/can_pin_mux.sv
module can_pin_mux
  import can_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  eng_tx_i,
  input  logic  eng_err_flag_i,
  input  logic  pin_rx_i,
  output logic  pin_tx_o,
  output logic  pin_tx_oe_o,
  output logic  eng_rx_o
);
  localparam logic RECESSIVE = 1'b1;

  always_comb begin
    pin_tx_o    = RECESSIVE;
    pin_tx_oe_o = 1'b0;
    eng_rx_o    = RECESSIVE;
    unique case (mode_i)
      MD_NORMAL: begin
        pin_tx_o    = eng_tx_i;
        pin_tx_oe_o = 1'b1;
        eng_rx_o    = pin_rx_i;
      end
      MD_LISTEN: eng_rx_o = pin_rx_i;
      MD_LOOP:   eng_rx_o = eng_tx_i;
      MD_ERRREC: begin
        // error flags never reach the bus
        pin_tx_o    = eng_err_flag_i ? RECESSIVE : eng_tx_i;
        pin_tx_oe_o = 1'b1;
        eng_rx_o    = pin_rx_i;
      end
      default: ;
    endcase
  end

  // R4
  silent_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_silent(mode_i) |-> (pin_tx_o && !pin_tx_oe_o));

  // R5
  loop_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_LOOP) |-> (eng_rx_o == eng_tx_i));

  // R6
  errflag_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_ERRREC && eng_err_flag_i) |-> pin_tx_o);
endmodule

// File: rtl/can_err_policy.sv
module can_err_policy
  import can_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  err_evt_i,
  output logic  ack_ignore_o,
  output logic  cnt_hold_o,
  output logic  cnt_clr_o,
  output logic  keep_err_o,
  output logic  copy_part_o,
  output logic  rx_en_o
);
  logic copy_q;
  logic store_err;

  assign store_err    = (mode_i == MD_LISTEN) || (mode_i == MD_ERRREC);
  assign ack_ignore_o = (mode_i == MD_LOOP);
  assign cnt_clr_o    = (mode_i == MD_LISTEN);
  assign cnt_hold_o   = store_err;
  assign keep_err_o   = store_err;
  assign rx_en_o      = (mode_i != MD_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) copy_q <= 1'b0;
    else         copy_q <= err_evt_i && store_err;
  end

  assign copy_part_o = copy_q;

  // R7
  copy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_part_o |-> $past(err_evt_i));

  // R9
  cfg_rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_CFG) |-> (!rx_en_o && !copy_part_o || !rx_en_o));
endmodule

// File: rtl/can_mode_gate.sv
module can_mode_gate
  import can_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_req_i,
  input  logic              bus_idle_i,
  input  logic              eng_tx_i,
  input  logic              eng_err_flag_i,
  input  logic              pin_rx_i,
  input  logic              err_evt_i,
  output logic              pin_tx_o,
  output logic              pin_tx_oe_o,
  output logic              eng_rx_o,
  output logic              ack_ignore_o,
  output logic              cnt_hold_o,
  output logic              cnt_clr_o,
  output logic              keep_err_o,
  output logic              copy_part_o,
  output logic              rx_en_o,
  output logic [MODE_W-1:0] mode_ack_o
);
  mode_e mode;

  can_mode_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (mode_req_i),
    .bus_idle_i (bus_idle_i),
    .mode_o     (mode)
  );

  can_pin_mux u_pin (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_i         (mode),
    .eng_tx_i       (eng_tx_i),
    .eng_err_flag_i (eng_err_flag_i),
    .pin_rx_i       (pin_rx_i),
    .pin_tx_o       (pin_tx_o),
    .pin_tx_oe_o    (pin_tx_oe_o),
    .eng_rx_o       (eng_rx_o)
  );

  can_err_policy u_pol (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .err_evt_i    (err_evt_i),
    .ack_ignore_o (ack_ignore_o),
    .cnt_hold_o   (cnt_hold_o),
    .cnt_clr_o    (cnt_clr_o),
    .keep_err_o   (keep_err_o),
    .copy_part_o  (copy_part_o),
    .rx_en_o      (rx_en_o)
  );

  assign mode_ack_o = mode;

  // R3
  normal_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ack_o == 3'd1) |-> (pin_tx_o == eng_tx_i && eng_rx_o == pin_rx_i && pin_tx_oe_o));
endmodule

// File: tb/sim_can_mode_gate.sv
module sim_can_mode_gate;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = 3'd0;
  logic       idle = 1'b1, tx = 1'b1, flag = 1'b0, rx = 1'b1, err = 1'b0;
  logic       pin_tx, pin_oe, eng_rx, ack_ign, hold, clr, keep, copy, rx_en;
  logic [2:0] mode_ack;

  int checks = 0;
  int failures = 0;
  logic [2:0] model_mode = 3'd0;

  typedef struct {
    logic [11:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  can_mode_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_req_i(req), .bus_idle_i(idle),
    .eng_tx_i(tx), .eng_err_flag_i(flag), .pin_rx_i(rx), .err_evt_i(err),
    .pin_tx_o(pin_tx), .pin_tx_oe_o(pin_oe), .eng_rx_o(eng_rx),
    .ack_ignore_o(ack_ign), .cnt_hold_o(hold), .cnt_clr_o(clr),
    .keep_err_o(keep), .copy_part_o(copy), .rx_en_o(rx_en), .mode_ack_o(mode_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] actual();
    return {mode_ack, pin_tx, pin_oe, eng_rx, ack_ign, hold, clr, keep, copy, rx_en};
  endfunction

  // expected outputs built from the requirement text
  function automatic logic [11:0] expect_of(input logic [2:0] m, input logic cp);
    logic ptx, poe, erx, ai, hd, cl, kp, re;
    ptx = 1; poe = 0; erx = 1; ai = 0; hd = 0; cl = 0; kp = 0; re = (m != 0);
    case (m)
      3'd1: begin ptx = tx; poe = 1; erx = rx; end
      3'd2: begin erx = rx; cl = 1; hd = 1; kp = 1; end
      3'd3: begin erx = tx; ai = 1; end
      3'd4: begin ptx = flag ? 1'b1 : tx; poe = 1; erx = rx; hd = 1; kp = 1; end
      default: ;
    endcase
    return {m, ptx, poe, erx, ai, hd, cl, kp, cp, re};
  endfunction

  task automatic check(input logic [11:0] a, input logic [11:0] e, input string tag);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, a, e);
    end
  endtask

  task automatic step(input logic [2:0] r, input logic i, input logic t,
                      input logic f, input logic x, input logic e, input string tag);
    item_t it;
    logic [2:0] prev;
    @(negedge clk);
    req = r; idle = i; tx = t; flag = f; rx = x; err = e;
    prev = model_mode;
    if (i && r <= 3'd4) model_mode = r;
    it.exp = expect_of(model_mode, e && (prev == 3'd2 || prev == 3'd4));
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(actual(), it.exp, it.tag);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    check(actual(), {3'd0, 1'b1, 1'b0, 1'b1, 5'b0, 1'b0}, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    step(3'd1, 1, 0, 0, 1, 0, "R2 enter normal");
    step(3'd1, 1, 1, 0, 0, 0, "R3 normal passthrough");
    step(3'd1, 1, 0, 1, 1, 0, "R3 normal drives dominant");
    step(3'd2, 0, 0, 0, 1, 0, "R2 busy bus blocks switch");
    step(3'd2, 0, 1, 0, 0, 1, "R7 no copy in normal");
    step(3'd2, 1, 0, 0, 0, 0, "R4 listen silent rx0");
    step(3'd2, 1, 0, 0, 1, 1, "R7 copy in listen");
    step(3'd7, 1, 0, 0, 0, 0, "R8 code 7 ignored");
    step(3'd3, 1, 0, 0, 1, 0, "R5 loopback tx0 rx1");
    step(3'd3, 1, 1, 0, 0, 0, "R5 loopback tx1 rx0");
    step(3'd3, 1, 0, 0, 1, 1, "R7 no copy in loopback");
    step(3'd4, 1, 0, 0, 1, 0, "R6 errrec drives tx");
    step(3'd4, 1, 0, 1, 1, 0, "R6 errrec masks error flag");
    step(3'd4, 1, 1, 0, 0, 1, "R7 copy in errrec");
    step(3'd6, 1, 1, 0, 0, 0, "R8 code 6 ignored");
    step(3'd0, 1, 0, 0, 0, 0, "R9 config blocks rx");
    step(3'd5, 1, 0, 0, 0, 0, "R8 code 5 ignored");
    step(3'd2, 0, 0, 0, 0, 0, "R9 config held while busy");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule